// File: doc/BRIEF.md
# Interrupt Controller with Normal/Fast Line Steering

This block collects level-sensitive interrupt requests from up to 32 sources and drives two request lines toward a processor: a normal line and a fast line. Each source passes through a per-source enable (mask) bit. A per-source steering bit then sends an enabled, active source to exactly one of the two lines. Software sees three read-only views of the request state: what is pending on the normal line, what is pending on the fast line, and every raw active request whatever its mask or steering.

Software reaches the mask, steering and control registers through a simple word-addressed register port. A single strobe `bus_sel` qualifies an access, and `bus_we` selects a write or a read. Read data is registered: it appears one cycle after the read strobe and is zero in any cycle that follows no read. The port is a plain control interface with no back-pressure, so every access completes in the cycle it is presented.

Source 14 is a hole. It has no storage and never shows in any view or output.

The block also provides an idle-wakeup indication. A control bit chooses between two behaviours for it: it follows any active request, or only requests whose mask bit is set. Prioritising, vectoring, nesting and edge capture are handled elsewhere.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset the mask, steering and control registers read 0, and `irq_o`, `fiq_o`, `wake_o` and `bus_rdata` are all 0.
- R2: A source whose mask bit is 0 never appears in the normal-pending or fast-pending view and never raises `irq_o` or `fiq_o`.
- R3: An active source with mask bit 1 appears in the normal-pending view (word 0) when its steering bit (word 2) is 0, and in the fast-pending view (word 4) when that bit is 1. It never appears in both.
- R4: `irq_o` equals the OR of the normal-pending bits and `fiq_o` equals the OR of the fast-pending bits, each as sampled at the previous clock edge. A change on `src_req` therefore reaches the outputs at the first rising edge after it.
- R5: The all-pending view (word 8) shows every active request, whatever the mask and steering bits hold.
- R6: Source 14 is unused. It never appears in any view and never raises an output, and bit 14 of the mask and steering registers always reads 0.
- R7: Writes to words 0, 4 and 8 (the pending views) change no register and no output.
- R8: Reads of any word index other than 0, 1, 2, 3, 4 and 8 return 0, and writes to those indices change nothing.
- R9: Control word 3 holds only bit 0; its other bits read 0. When bit 0 is 0, `wake_o` is the registered OR of all active requests. When bit 0 is 1, `wake_o` is the registered OR of active requests whose mask bit is 1.
- R10: A read presented at edge k returns its data on `bus_rdata` after edge k. `bus_rdata` is 0 after any edge at which no read was presented.
- R11: A write to the mask (word 1) or steering (word 2) register at edge k takes effect at edge k, and the outputs reflect the new value from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 32 | Level-sensitive request per source |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read, when `bus_sel` is 1 |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |
| wake_o | output | 1 | Idle-wakeup indication |

## Verification
Read data is due one edge after the read strobe. The driver pushes each expected word into a queue at the falling edge where it presents the read, and the monitor pops and compares 2 ns after the next rising edge.

A change on `src_req` made at a falling edge is due on `irq_o`, `fiq_o` and `wake_o` after the following rising edge. A register write shows on those outputs one edge later than that. The bench samples the outputs at falling edges placed to match each of these delays, and it also checks that the old value still holds in the cycle just before a write lands.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned WIDX_W = 4;

  // Word indices on the register port (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_IPEND = 4'h0;
  localparam logic [WIDX_W-1:0] W_MASK  = 4'h1;
  localparam logic [WIDX_W-1:0] W_STEER = 4'h2;
  localparam logic [WIDX_W-1:0] W_CTRL  = 4'h3;
  localparam logic [WIDX_W-1:0] W_FPEND = 4'h4;
  localparam logic [WIDX_W-1:0] W_APEND = 4'h8;

  function automatic logic is_storable(input logic [WIDX_W-1:0] idx);
    return (idx == W_MASK) || (idx == W_STEER) || (idx == W_CTRL);
  endfunction

  function automatic logic is_readable(input logic [WIDX_W-1:0] idx);
    return is_storable(idx) || (idx == W_IPEND) || (idx == W_FPEND) || (idx == W_APEND);
  endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned          N_SRC = 32,
  parameter logic [N_SRC-1:0]     HOLES = 32'h0000_4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WIDX_W-1:0]  wr_idx,
  input  logic [N_SRC-1:0]   wr_data,
  output logic [N_SRC-1:0]   mask_q,
  output logic [N_SRC-1:0]   steer_q,
  output logic               ctl_q
);

  localparam logic [N_SRC-1:0] LIVE = ~HOLES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      steer_q <= '0;
      ctl_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_idx)
        W_MASK:  mask_q  <= wr_data & LIVE;
        W_STEER: steer_q <= wr_data & LIVE;
        W_CTRL:  ctl_q   <= wr_data[0];
        default: ;
      endcase
    end
  end

  // R7 / R8: writes to views or unmapped words leave storage untouched
  a_r8_unstored_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_storable(wr_idx)) |=> ($stable(mask_q) && $stable(steer_q) && $stable(ctl_q)));

endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int unsigned      N_SRC = 32,
  parameter logic [N_SRC-1:0] HOLES = 32'h0000_4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   req,
  input  logic [N_SRC-1:0]   mask_q,
  input  logic [N_SRC-1:0]   steer_q,
  input  logic               ctl_q,
  output logic [N_SRC-1:0]   raw,
  output logic [N_SRC-1:0]   ipend,
  output logic [N_SRC-1:0]   fpend,
  output logic               wake_d
);

  logic [N_SRC-1:0] enabled;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (HOLES[g]) begin : g_hole
      assign raw[g]     = 1'b0;
      assign enabled[g] = 1'b0;
      assign ipend[g]   = 1'b0;
      assign fpend[g]   = 1'b0;
    end else begin : g_live
      assign raw[g]     = req[g];
      assign enabled[g] = req[g] & mask_q[g];
      assign ipend[g]   = enabled[g] & ~steer_q[g];
      assign fpend[g]   = enabled[g] &  steer_q[g];
    end
  end

  assign wake_d = ctl_q ? (|enabled) : (|raw);

  // R2: nothing pending without its mask bit
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipend | fpend) & ~mask_q) == '0);

  // R3: a source is steered to one line only
  a_r3_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    (ipend & fpend) == '0);

  // R6: unused sources never show as active
  a_r6_hole_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & HOLES) == '0);

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [WIDX_W-1:0]  rd_idx,
  input  logic [N_SRC-1:0]   mask_q,
  input  logic [N_SRC-1:0]   steer_q,
  input  logic               ctl_q,
  input  logic [N_SRC-1:0]   ipend,
  input  logic [N_SRC-1:0]   fpend,
  input  logic [N_SRC-1:0]   raw,
  output logic [N_SRC-1:0]   rdata_q
);

  logic [N_SRC-1:0] sel_word;

  always_comb begin
    case (rd_idx)
      W_IPEND: sel_word = ipend;
      W_MASK:  sel_word = mask_q;
      W_STEER: sel_word = steer_q;
      W_CTRL:  sel_word = {{(N_SRC-1){1'b0}}, ctl_q};
      W_FPEND: sel_word = fpend;
      W_APEND: sel_word = raw;
      default: sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_en)  rdata_q <= sel_word;
    else             rdata_q <= '0;
  end

  // R8: unmapped words read as zero
  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_readable(rd_idx)) |=> (rdata_q == '0));

  // R10: idle cycles return zero
  a_r10_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata_q == '0));

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned      N_SRC = 32,
  parameter logic [N_SRC-1:0] HOLES = 32'h0000_4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_req,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [WIDX_W-1:0]  bus_word,
  input  logic [N_SRC-1:0]   bus_wdata,
  output logic [N_SRC-1:0]   bus_rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);

  logic             wr_en, rd_en;
  logic [N_SRC-1:0] mask_q, steer_q;
  logic             ctl_q;
  logic [N_SRC-1:0] raw, ipend, fpend;
  logic             wake_d;

  assign wr_en = bus_sel &  bus_we;
  assign rd_en = bus_sel & ~bus_we;

  irqc_regs #(.N_SRC(N_SRC), .HOLES(HOLES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (bus_word),
    .wr_data (bus_wdata),
    .mask_q  (mask_q),
    .steer_q (steer_q),
    .ctl_q   (ctl_q)
  );

  irqc_route #(.N_SRC(N_SRC), .HOLES(HOLES)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (src_req),
    .mask_q  (mask_q),
    .steer_q (steer_q),
    .ctl_q   (ctl_q),
    .raw     (raw),
    .ipend   (ipend),
    .fpend   (fpend),
    .wake_d  (wake_d)
  );

  irqc_rdmux #(.N_SRC(N_SRC)) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_idx  (bus_word),
    .mask_q  (mask_q),
    .steer_q (steer_q),
    .ctl_q   (ctl_q),
    .ipend   (ipend),
    .fpend   (fpend),
    .raw     (raw),
    .rdata_q (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |ipend;
      fiq_o  <= |fpend;
      wake_o <= wake_d;
    end
  end

  // R4: each line follows its pending view one edge later
  a_r4_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (|ipend) |=> irq_o);
  a_r4_fiq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fpend) |=> !fiq_o);

  // R9: with the gate set, masked-off requests cannot wake
  a_r9_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q && ((raw & mask_q) == '0)) |=> !wake_o);

endmodule

// File: tb/irq_steer_ctrl_tb.sv
module irq_steer_ctrl_tb;

  localparam logic [31:0] HOLE = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, wake_o;

  always #4 clk = ~clk;  // 125 MHz

  irq_steer_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sbq[$];

  logic [31:0] sh_mask = '0, sh_steer = '0, sh_req = '0;
  logic        sh_ctl = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_raw();
    return sh_req & ~HOLE;
  endfunction
  function automatic logic [31:0] m_ip();
    return m_raw() & sh_mask & ~sh_steer;
  endfunction
  function automatic logic [31:0] m_fp();
    return m_raw() & sh_mask & sh_steer;
  endfunction
  function automatic logic m_wake();
    return sh_ctl ? |(m_raw() & sh_mask) : |m_raw();
  endfunction

  // Monitor: read data is due just after the edge following the strobe
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.tag, bus_rdata, e.v);
    end
  end

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_word = idx;
    sbq.push_back('{exp, tag});
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = idx; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    case (idx)
      4'h1: sh_mask  = data & ~HOLE;
      4'h2: sh_steer = data & ~HOLE;
      4'h3: sh_ctl   = data[0];
      default: ;
    endcase
  endtask

  task automatic setreq(input logic [31:0] v);
    @(negedge clk);
    src_req = v; sh_req = v;
    @(negedge clk);  // one edge has passed: outputs due now
  endtask

  task automatic chk_out(input string tag);
    chk({tag, " irq_o"},  {31'b0, irq_o},  {31'b0, |m_ip()});
    chk({tag, " fiq_o"},  {31'b0, fiq_o},  {31'b0, |m_fp()});
    chk({tag, " wake_o"}, {31'b0, wake_o}, {31'b0, m_wake()});
  endtask

  task automatic chk_views(input string tag);
    rd(4'h0, m_ip(),  {tag, " normal view"});
    rd(4'h4, m_fp(),  {tag, " fast view"});
    rd(4'h8, m_raw(), {tag, " all view"});
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    chk_out("R1 in reset");
    rst_n = 1'b1;
    rd(4'h1, 32'h0, "R1 mask reset");
    rd(4'h2, 32'h0, "R1 steer reset");
    rd(4'h3, 32'h0, "R1 ctrl reset");

    // R2 / R5 / R6: all requests active, everything masked
    setreq(32'hFFFF_FFFF);
    chk_out("R2 all masked");
    chk_views("R5 R6 masked");

    // R3 / R4: steer a mixed set
    wr(4'h1, 32'h0000_00F0);
    wr(4'h2, 32'h0000_00C0);
    @(negedge clk);
    chk_out("R3 mixed steer");
    chk_views("R3 mixed steer");

    // R6: hole bit never stored
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h2, 32'hFFFF_FFFF);
    rd(4'h1, 32'hFFFF_BFFF, "R6 mask bit14");
    rd(4'h2, 32'hFFFF_BFFF, "R6 steer bit14");
    wr(4'h2, 32'h0);
    setreq(32'h0000_4000);
    chk_out("R6 hole only");
    chk_views("R6 hole only");

    // R4: single source on the fast line, then release
    wr(4'h2, 32'h0000_0008);
    setreq(32'h0000_0008);
    chk_out("R4 fast raise");
    chk("R4 fiq_o high", {31'b0, fiq_o}, 32'h1);
    setreq(32'h0000_0000);
    chk("R4 fiq_o drop", {31'b0, fiq_o}, 32'h0);
    chk_out("R4 all low");

    // R7: writes to views are ignored
    setreq(32'h0000_0109);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'h1234_5678);
    rd(4'h1, sh_mask,  "R7 mask kept");
    rd(4'h2, sh_steer, "R7 steer kept");
    rd(4'h3, 32'h0,    "R7 ctrl kept");
    chk_views("R7 views unchanged");
    chk_out("R7 outputs unchanged");

    // R8: unmapped words
    for (int i = 5; i < 16; i++) begin
      if (i != 8) begin
        wr(4'(i), 32'hFFFF_FFFF);
        rd(4'(i), 32'h0, "R8 unmapped read");
      end
    end
    rd(4'h1, sh_mask,  "R8 mask kept");
    rd(4'h2, sh_steer, "R8 steer kept");
    rd(4'h3, 32'h0,    "R8 ctrl kept");

    // R9: wake gating
    wr(4'h3, 32'hFFFF_FFFF);
    rd(4'h3, 32'h1, "R9 ctrl only bit0");
    wr(4'h1, 32'h0);
    setreq(32'h0000_0600);
    chk("R9 gated wake low", {31'b0, wake_o}, 32'h0);
    wr(4'h1, 32'h0000_0200);
    @(negedge clk);
    chk("R9 gated wake high", {31'b0, wake_o}, 32'h1);
    wr(4'h3, 32'h0);
    wr(4'h1, 32'h0);
    @(negedge clk);
    chk("R9 ungated wake high", {31'b0, wake_o}, 32'h1);
    setreq(32'h0000_4000);
    chk("R9 hole cannot wake", {31'b0, wake_o}, 32'h0);

    // R11: write lands one edge before the outputs move
    wr(4'h2, 32'h0);
    setreq(32'h0000_0020);
    chk("R11 irq_o before write", {31'b0, irq_o}, 32'h0);
    wr(4'h1, 32'h0000_0020);
    chk("R11 irq_o at write edge", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R11 irq_o after write", {31'b0, irq_o}, 32'h1);
    wr(4'h2, 32'h0000_0020);
    chk("R11 fiq_o at write edge", {31'b0, fiq_o}, 32'h0);
    @(negedge clk);
    chk("R11 fiq_o after write", {31'b0, fiq_o}, 32'h1);
    chk("R11 irq_o moved away", {31'b0, irq_o}, 32'h0);

    // R10: read data lasts one cycle only
    rd(4'h1, 32'h0000_0020, "R10 read data");
    @(negedge clk);
    chk("R10 idle rdata", bus_rdata, 32'h0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule